// File: doc/BRIEF.md
# Maskable Pin-Change Interrupt Controller

This block watches a bank of general-purpose pins and latches a sticky flag for every pin that is configured as an input and changes level, in either direction. Each flag is kept in a per-pin status register. A pin's flag reaches the interrupt line only when the pin's enable bit is set. The interrupt line has a programmable active level and an output-enable that lets the pad float when interrupts are switched off.

Software works through a byte-wide register port. The port reaches a control byte, two enable-mask bytes and two status bytes. A read of a status byte returns the pending flags and clears them. A write to the control byte can also fire a soft reset, which clears all the block's state. The bus transport and the pad drivers sit outside this block.

Top module: `pcirq_top`

## Requirements
- R1: A level change in either direction on a pin whose direction bit is 0 (input) sets that pin's status bit. The bit reads back as set by the third rising clock edge after the change.
- R2: A change on a pin whose direction bit is 1 (output) sets nothing. A change that reaches the edge detector in the first cycle after the pin switches from output to input is also ignored.
- R3: Status bits are set whatever the enable mask holds.
- R4: Writes to the status bytes (0x0A for pins 7..0, 0x0B for pins 15..8) have no effect.
- R5: A read of a status byte returns its flags and clears the bits set in that byte only. The other byte keeps its flags.
- R6: A transition detected in the same cycle as a clearing read of its byte leaves the bit set.
- R7: Enable-mask bytes sit at 0x08 (pins 7..0) and 0x09 (pins 15..8) and reset to 0. Bit x lets pin x's status reach the interrupt.
- R8: Let "pending" be the OR over all pins of status AND enable. With control bit 0 = 1, `irq_o` equals pending; with control bit 0 = 0, `irq_o` equals NOT pending.
- R9: The control byte is at 0x03 and resets to 0x00. Bit 2 drives `irq_oe_o`, bit 6 drives `shutdown_req_o` and bit 5 drives `wake_en_o`. Bits 1, 3 and 4 read as 0.
- R10: Writing control bit 7 = 1 clears the control byte, the enable mask and the status in that same cycle. Bit 7 always reads as 0.
- R11: Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Raw pin levels, asynchronous |
| dir_out_i | input | 16 | Pin direction, 1 = output |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a status read clears on this edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt level, polarity per control bit 0 |
| irq_oe_o | output | 1 | Interrupt pad output enable |
| shutdown_req_o | output | 1 | Bus-shutdown request bit |
| wake_en_o | output | 1 | Wake-up enable bit |

## Verification
The assertions check on every cycle that a status bit rises only after a detected edge and falls only on a clearing read or a soft reset. They also check that a detected edge is never lost to a simultaneous clear, that mask writes land, and that the soft reset empties everything. Other behaviours appear only in the bench scenarios: read-data values, the polarity and output-enable mapping, the suppression of the first sample after a direction change, and byte-wise independence of clearing. Each of these needs a specific sequence of pin and register traffic.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h03;
  localparam logic [7:0] ADDR_MASK = 8'h08;
  localparam logic [7:0] ADDR_STAT = 8'h0A;
  localparam int CTRL_POL  = 0;
  localparam int CTRL_OE   = 2;
  localparam int CTRL_WAKE = 5;
  localparam int CTRL_SHDN = 6;
  localparam int CTRL_SRST = 7;
endpackage

// File: rtl/pcirq_edge.sv
module pcirq_edge #(
  parameter int N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] dir_out_i,
  output logic [N_PINS-1:0] edge_o
);
  logic [N_PINS-1:0] s1_q, s2_q, prev_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      dir_q  <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      dir_q  <= dir_out_i;
    end
  end

  // qualify only pins that were inputs both now and last cycle
  assign edge_o = (s2_q ^ prev_q) & ~dir_out_i & ~dir_q;

  assert_no_edge_on_output_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o & $past(dir_out_i)) == '0);
endmodule

// File: rtl/pcirq_status.sv
module pcirq_status #(
  parameter int N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [N_PINS-1:0] edge_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] status_o
);
  logic [N_PINS-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (srst_i) st_q <= '0;
    else             st_q <= (st_q & ~clr_i) | edge_i;
  end

  assign status_o = st_q;

  assert_set_needs_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & ~$past(st_q) & ~$past(edge_i)) == '0);

  assert_drop_needs_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(st_q) & ~st_q & ~$past(clr_i)) != '0) |-> $past(srst_i));

  assert_edge_wins_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(srst_i) |-> (($past(edge_i) & ~st_q) == '0));
endmodule

// File: rtl/pcirq_out.sv
module pcirq_out #(
  parameter int N_PINS = 16
) (
  input  logic [N_PINS-1:0] status_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic              pol_high_i,
  output logic              irq_o
);
  logic pending;
  assign pending = |(status_i & mask_i);
  assign irq_o   = pending ^ ~pol_high_i;
endmodule

// File: rtl/pcirq_top.sv
module pcirq_top
  import pcirq_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] dir_out_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              irq_oe_o,
  output logic              shutdown_req_o,
  output logic              wake_en_o
);
  localparam int N_BYTES = N_PINS / 8;

  logic [N_PINS-1:0] edge_det, status, mask_q, clr;
  logic              pol_q, oe_q, wake_q, shdn_q;
  logic              ctrl_wr, srst;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign srst    = ctrl_wr && reg_wdata_i[CTRL_SRST];

  pcirq_edge #(.N_PINS(N_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .dir_out_i(dir_out_i), .edge_o(edge_det)
  );

  pcirq_status #(.N_PINS(N_PINS)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst),
    .edge_i(edge_det), .clr_i(clr), .status_o(status)
  );

  pcirq_out #(.N_PINS(N_PINS)) u_out (
    .status_i(status), .mask_i(mask_q), .pol_high_i(pol_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0; oe_q <= 1'b0; wake_q <= 1'b0; shdn_q <= 1'b0;
    end else if (srst) begin
      pol_q <= 1'b0; oe_q <= 1'b0; wake_q <= 1'b0; shdn_q <= 1'b0;
    end else if (ctrl_wr) begin
      pol_q  <= reg_wdata_i[CTRL_POL];
      oe_q   <= reg_wdata_i[CTRL_OE];
      wake_q <= reg_wdata_i[CTRL_WAKE];
      shdn_q <= reg_wdata_i[CTRL_SHDN];
    end
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    localparam logic [7:0] MASK_A = 8'(int'(ADDR_MASK) + b);
    localparam logic [7:0] STAT_A = 8'(int'(ADDR_STAT) + b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mask_q[8*b +: 8] <= '0;
      else if (srst)                             mask_q[8*b +: 8] <= '0;
      else if (reg_wr_i && reg_addr_i == MASK_A) mask_q[8*b +: 8] <= reg_wdata_i;
    end

    assign clr[8*b +: 8] = {8{reg_rd_i && reg_addr_i == STAT_A}};

    assert_mask_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == MASK_A && !srst) |=> mask_q[8*b +: 8] == $past(reg_wdata_i));
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o[CTRL_POL]  = pol_q;
      reg_rdata_o[CTRL_OE]   = oe_q;
      reg_rdata_o[CTRL_WAKE] = wake_q;
      reg_rdata_o[CTRL_SHDN] = shdn_q;
    end
    for (int b = 0; b < N_BYTES; b++) begin
      if (reg_addr_i == 8'(int'(ADDR_MASK) + b)) reg_rdata_o = mask_q[8*b +: 8];
      if (reg_addr_i == 8'(int'(ADDR_STAT) + b)) reg_rdata_o = status[8*b +: 8];
    end
  end

  assign irq_oe_o       = oe_q;
  assign shutdown_req_o = shdn_q;
  assign wake_en_o      = wake_q;

  assert_soft_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (mask_q == '0) && (status == '0) && !oe_q && !pol_q && !shdn_q && !wake_q);
endmodule

// File: tb/tb_pcirq_top.sv
module tb_pcirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0, dir = '0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr = 1'b0, rd = 1'b0;
  logic        irq, irq_oe, shdn, wake;
  int          n_vec = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pcirq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_out_i(dir),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe),
    .shutdown_req_o(shdn), .wake_en_o(wake)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(8'h03, d); check("R9 ctrl reset", d, 8'h00);
    peek(8'h08, d); check("R7 mask lo reset", d, 8'h00);
    peek(8'h09, d); check("R7 mask hi reset", d, 8'h00);
    check("R8 irq idle active-low", irq, 1'b1);
    check("R9 oe reset", irq_oe, 1'b0);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    @(negedge clk); pin[3] = 1'b1; pin[12] = 1'b1;
    cyc(3);
    peek(8'h0A, d); check("R1 rise lo / R3 masked", d, 8'h08);
    rd_reg(8'h0B, d); check("R1 rise hi", d, 8'h10);
    peek(8'h0B, d); check("R5 hi cleared", d, 8'h00);
    peek(8'h0A, d); check("R5 lo untouched", d, 8'h08);
    rd_reg(8'h0A, d);
    @(negedge clk); pin[3] = 1'b0;
    cyc(3);
    rd_reg(8'h0A, d); check("R1 fall", d, 8'h08);
    wr_reg(8'h0A, 8'hFF); wr_reg(8'h0B, 8'hFF);
    peek(8'h0A, d); check("R4 write lo ignored", d, 8'h00);
    peek(8'h0B, d); check("R4 write hi ignored", d, 8'h00);
  endtask

  task automatic t_direction;
    logic [7:0] d;
    @(negedge clk); dir[1] = 1'b1;
    cyc(2);
    @(negedge clk); pin[1] = 1'b1;
    cyc(4);
    peek(8'h0A, d); check("R2 output pin ignored", d, 8'h00);
    @(negedge clk); pin[1] = 1'b0;
    cyc(1);
    @(negedge clk); dir[1] = 1'b0;
    cyc(3);
    peek(8'h0A, d); check("R2 first sample after turn ignored", d, 8'h00);
    @(negedge clk); pin[1] = 1'b1;
    cyc(3);
    rd_reg(8'h0A, d); check("R2 input again detects", d, 8'h02);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk); pin[0] = 1'b1;
    cyc(3);
    @(negedge clk); pin[0] = 1'b0;
    cyc(1);
    @(negedge clk); addr = 8'h0A; rd = 1'b1; #1 d = rdata;
    check("R6 read sees old flag", d, 8'h01);
    @(negedge clk); rd = 1'b0;
    peek(8'h0A, d); check("R6 new edge kept", d, 8'h01);
    rd_reg(8'h0A, d);
    peek(8'h0A, d); check("R5 cleared after read", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr_reg(8'h03, 8'h65);
    peek(8'h03, d); check("R9 ctrl readback", d, 8'h65);
    check("R9 oe/shdn/wake", {irq_oe, shdn, wake}, 3'b111);
    wr_reg(8'h03, 8'h7F);
    peek(8'h03, d); check("R9 reserved read 0", d, 8'h65);
    check("R8 high pol idle", irq, 1'b0);
    @(negedge clk); pin[9] = 1'b1;
    cyc(3);
    check("R7 masked no irq", irq, 1'b0);
    wr_reg(8'h09, 8'h02);
    peek(8'h09, d); check("R7 mask readback", d, 8'h02);
    check("R8 high pol asserted", irq, 1'b1);
    wr_reg(8'h03, 8'h04);
    check("R8 low pol asserted", irq, 1'b0);
    rd_reg(8'h0B, d);
    check("R8 low pol released", irq, 1'b1);
    peek(8'h20, d); check("R11 unmapped", d, 8'h00);
  endtask

  task automatic t_soft_reset;
    logic [7:0] d;
    wr_reg(8'h08, 8'hA5);
    wr_reg(8'h03, 8'h45);
    @(negedge clk); pin[5] = 1'b1;
    cyc(3);
    wr_reg(8'h03, 8'h85);
    peek(8'h03, d); check("R10 ctrl cleared, bit7 reads 0", d, 8'h00);
    peek(8'h08, d); check("R10 mask cleared", d, 8'h00);
    peek(8'h0A, d); check("R10 status cleared", d, 8'h00);
    check("R10 outputs cleared", {irq_oe, shdn}, 2'b00);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_edges();
    t_direction();
    t_collide();
    t_irq();
    t_soft_reset();
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule